// File: doc/BRIEF.md
# DMA Channel Eligibility Arbiter

This block sits in front of a DMA transfer engine and decides which channel may move its next transfer unit. Each cycle it captures every channel's configuration and control words, the controller-wide configuration word and the peripheral request lines into a register stage. It then qualifies every channel from those registered values. A channel qualifies when it is enabled and not halted, still has transfer units left, and its flow type finds the peripheral requests it needs. A fixed-priority picker then grants the lowest-numbered qualifying channel.

The grant is issued as a valid signal with the engine's busy line acting as back-pressure. While `engine_busy_i` is high, no grant is presented and nothing is consumed. Once busy drops, the grant reflects the registered inputs in the same cycle. A grant is presented for as long as a channel qualifies. A channel programmed with a flow type the block cannot serve, meaning types 4 to 7 where the peripheral controls the flow, is never granted. It also raises a per-channel error flag that stays set until reset.

Top module: `dma_chan_arbiter`

## Requirements
- R1: A channel can only be granted when its configuration bit 0 (enable) is 1 and bit 18 (halt) is 0.
- R2: The flow type is configuration bits 13:11, the source peripheral ID is bits 5:1 and the destination peripheral ID is bits 10:6. Type 0 needs no request. Type 1 needs the request line of the destination ID. Type 2 needs the request line of the source ID. Type 3 needs both.
- R3: A peripheral counts as requesting when its bit is set in either `req_single_i` or `req_burst_i`.
- R4: A channel whose control bits 11:0 (remaining units) are zero is never granted.
- R5: `grant_o` is one-hot or zero. `grant_idx_o` names the granted bit. The lowest-numbered qualifying channel wins, and it keeps winning while it qualifies.
- R6: While bit 0 of `ctrl_cfg_i` is 0, `grant_valid_o` stays low.
- R7: A channel with a flow type of 4 to 7 is never granted, and a higher-numbered channel can still be granted in its place. If such a channel is also enabled and not halted, its bit in `mode_err_o` sets and stays set until reset.
- R8: `grant_valid_o` is low in every cycle where `engine_busy_i` is high. Otherwise the grant follows the inputs that were sampled at the previous rising clock edge.
- R9: After reset, `grant_valid_o`, `grant_o` and `mode_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_cfg_i | input | W | Controller configuration word; bit 0 is the global enable |
| chan_cfg_i | input | NCH*W | Per-channel configuration words; channel c at [c*W +: W] |
| chan_ctl_i | input | NCH*W | Per-channel control words; bits 11:0 are the remaining count |
| req_single_i | input | NREQ | Single-transfer peripheral requests |
| req_burst_i | input | NREQ | Burst peripheral requests |
| engine_busy_i | input | 1 | Engine back-pressure; blocks the grant while high |
| grant_valid_o | output | 1 | A grant is presented |
| grant_o | output | NCH | One-hot granted channel |
| grant_idx_o | output | IDXW | Index of the granted channel |
| mode_err_o | output | NCH | Sticky unsupported-flow-type flags |

## Verification
The bench builds the block with four channels, 32-bit words and all 32 request lines. This makes it feasible to sweep every combination of enable, halt, zero count, the eight flow types, and the presence of the source and destination requests on one channel. Every non-empty set of eligible channels is also swept against the priority rule, with busy alternating. Global-enable, masking by an unsupported channel, and sticky-flag clearing by reset are checked directly.

// File: rtl/dma_elig_pkg.sv
package dma_elig_pkg;
  // Field positions inside a channel configuration word
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_HALT_BIT = 18;
  localparam int CFG_SRC_LO   = 1;
  localparam int CFG_DST_LO   = 6;
  localparam int CFG_FLOW_LO  = 11;
  localparam int ID_W         = 5;
  localparam int FLOW_W       = 3;
  // Remaining-count field inside a control word
  localparam int CNT_W        = 12;
  // Number of addressable peripheral request lines
  localparam int REQ_SPACE    = 1 << ID_W;

  typedef logic [FLOW_W-1:0] flow_t;

  localparam flow_t FLOW_MEM2MEM = 3'd0;
  localparam flow_t FLOW_MEM2PER = 3'd1;
  localparam flow_t FLOW_PER2MEM = 3'd2;
  localparam flow_t FLOW_PER2PER = 3'd3;

  function automatic logic flow_needs_src(input flow_t f);
    return (f == FLOW_PER2MEM) || (f == FLOW_PER2PER);
  endfunction

  function automatic logic flow_needs_dst(input flow_t f);
    return (f == FLOW_MEM2PER) || (f == FLOW_PER2PER);
  endfunction

  function automatic logic flow_unsupported(input flow_t f);
    return f[FLOW_W-1];
  endfunction
endpackage

// File: rtl/dma_in_stage.sv
module dma_in_stage #(
  parameter int NCH  = 8,
  parameter int W    = 32,
  parameter int NREQ = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      ctrl_cfg_i,
  input  logic [NCH*W-1:0]  chan_cfg_i,
  input  logic [NCH*W-1:0]  chan_ctl_i,
  input  logic [NREQ-1:0]   req_single_i,
  input  logic [NREQ-1:0]   req_burst_i,
  output logic              glob_en_q,
  output logic [NCH*W-1:0]  chan_cfg_q,
  output logic [NCH*W-1:0]  chan_ctl_q,
  output logic [NREQ-1:0]   req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en_q  <= 1'b0;
      chan_cfg_q <= '0;
      chan_ctl_q <= '0;
      req_q      <= '0;
    end else begin
      glob_en_q  <= ctrl_cfg_i[0];
      chan_cfg_q <= chan_cfg_i;
      chan_ctl_q <= chan_ctl_i;
      // Single and burst requests merge into one effective vector (R3)
      req_q      <= req_single_i | req_burst_i;
    end
  end
endmodule

// File: rtl/dma_chan_qual.sv
module dma_chan_qual
  import dma_elig_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    cfg_q,
  input  logic [W-1:0]    ctl_q,
  input  logic [NREQ-1:0] req_q,
  output logic            elig_o,
  output logic            err_o
);
  logic [REQ_SPACE-1:0] req_ext;
  logic [ID_W-1:0]      src_id, dst_id;
  flow_t                flow;
  logic                 live, cnt_nz, src_hit, dst_hit, req_ok, bad_flow;
  logic                 err_q;

  assign req_ext = REQ_SPACE'(req_q);

  always_comb begin
    flow     = cfg_q[CFG_FLOW_LO +: FLOW_W];
    src_id   = cfg_q[CFG_SRC_LO +: ID_W];
    dst_id   = cfg_q[CFG_DST_LO +: ID_W];
    live     = cfg_q[CFG_EN_BIT] & ~cfg_q[CFG_HALT_BIT];
    cnt_nz   = |ctl_q[CNT_W-1:0];
    src_hit  = req_ext[src_id];
    dst_hit  = req_ext[dst_id];
    bad_flow = flow_unsupported(flow);
    req_ok   = (!flow_needs_src(flow) || src_hit) &&
               (!flow_needs_dst(flow) || dst_hit);
    elig_o   = live & cnt_nz & ~bad_flow & req_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | (live & bad_flow);
  end

  assign err_o = err_q;

  // R7: the unsupported-mode flag never clears without reset
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R7: an enabled channel in an unsupported mode raises the flag next cycle
  p_err_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cfg_q[CFG_FLOW_LO+FLOW_W-1]) |=> err_q);
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH  = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  cand_i,
  output logic [NCH-1:0]  grant_o,
  output logic [IDXW-1:0] idx_o,
  output logic            valid_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (cand_i[c]) begin
        grant_o = '0;
        grant_o[c] = 1'b1;
        idx_o = IDXW'(c);
      end
    end
    valid_o = |cand_i;
  end

  // R5: at most one channel granted
  p_onehot_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R5: the reported index points at the granted bit
  p_idx_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> grant_o[idx_o]);

  // R5: no candidate below the winner is passed over
  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((cand_i & (grant_o - 1'b1)) == '0));
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_elig_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int W    = 32,
  parameter int NREQ = 32,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      ctrl_cfg_i,
  input  logic [NCH*W-1:0]  chan_cfg_i,
  input  logic [NCH*W-1:0]  chan_ctl_i,
  input  logic [NREQ-1:0]   req_single_i,
  input  logic [NREQ-1:0]   req_burst_i,
  input  logic              engine_busy_i,
  output logic              grant_valid_o,
  output logic [NCH-1:0]    grant_o,
  output logic [IDXW-1:0]   grant_idx_o,
  output logic [NCH-1:0]    mode_err_o
);
  logic             glob_en_q;
  logic [NCH*W-1:0] cfg_q, ctl_q;
  logic [NREQ-1:0]  req_q;
  logic [NCH-1:0]   elig, cand;

  dma_in_stage #(.NCH(NCH), .W(W), .NREQ(NREQ)) u_in (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_cfg_i   (ctrl_cfg_i),
    .chan_cfg_i   (chan_cfg_i),
    .chan_ctl_i   (chan_ctl_i),
    .req_single_i (req_single_i),
    .req_burst_i  (req_burst_i),
    .glob_en_q    (glob_en_q),
    .chan_cfg_q   (cfg_q),
    .chan_ctl_q   (ctl_q),
    .req_q        (req_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan_qual #(.W(W), .NREQ(NREQ)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_q  (cfg_q[c*W +: W]),
      .ctl_q  (ctl_q[c*W +: W]),
      .req_q  (req_q),
      .elig_o (elig[c]),
      .err_o  (mode_err_o[c])
    );
  end

  // Back-pressure and global enable gate every candidate (R6, R8)
  assign cand = elig & {NCH{glob_en_q & ~engine_busy_i}};

  dma_prio_pick #(.NCH(NCH), .IDXW(IDXW)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand_i  (cand),
    .grant_o (grant_o),
    .idx_o   (grant_idx_o),
    .valid_o (grant_valid_o)
  );

  // R8: nothing is offered while the engine is busy
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    engine_busy_i |-> !grant_valid_o);

  // R6: global enable clear means no grant
  p_glob_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en_q |-> !grant_valid_o);

  // R1/R4: a granted channel is enabled, not halted, with units left
  p_granted_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> (cfg_q[grant_idx_o*W + CFG_EN_BIT] &&
                       !cfg_q[grant_idx_o*W + CFG_HALT_BIT] &&
                       (ctl_q[grant_idx_o*W +: CNT_W] != '0)));

  // R7: a granted channel never carries an unsupported flow type
  p_granted_flow_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> !cfg_q[grant_idx_o*W + CFG_FLOW_LO + FLOW_W - 1]);
endmodule

// File: tb/dma_chan_arbiter_bench.sv
`timescale 1ns/1ps
module dma_chan_arbiter_bench;
  localparam int NCH = 4, W = 32, NREQ = 32, IDXW = 2;
  localparam int SRC_ID = 3, DST_ID = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] ctrl_cfg = '0;
  logic [NCH*W-1:0] cfg = '0, ctl = '0;
  logic [NREQ-1:0] rs = '0, rb = '0;
  logic busy = 1'b0;
  logic gv;
  logic [NCH-1:0] g, err;
  logic [IDXW-1:0] gi;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dma_chan_arbiter #(.NCH(NCH), .W(W), .NREQ(NREQ)) u_dma_chan_arbiter (
    .clk(clk), .rst_n(rst_n), .ctrl_cfg_i(ctrl_cfg), .chan_cfg_i(cfg),
    .chan_ctl_i(ctl), .req_single_i(rs), .req_burst_i(rb),
    .engine_busy_i(busy), .grant_valid_o(gv), .grant_o(g),
    .grant_idx_o(gi), .mode_err_o(err));

  function automatic logic [W-1:0] mk_cfg(input logic en, input logic halt,
      input int flow, input int src, input int dst);
    logic [W-1:0] v = '0;
    v[0] = en; v[18] = halt; v[13:11] = 3'(flow);
    v[5:1] = 5'(src); v[10:6] = 5'(dst);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int edges);
    for (int k = 0; k < edges; k++) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R9: reset state
    chk("R9 valid", 32'(gv), 0);
    chk("R9 grant", 32'(g), 0);
    chk("R9 err", 32'(err), 0);

    // Single-channel sweep over R1/R2/R3/R4/R7 conditions
    ctrl_cfg = 32'h1;
    for (int cse = 0; cse < 256; cse++) begin
      logic en, halt, cz, sr, dr, expv;
      int fl;
      fl = cse & 7; en = cse[3]; halt = cse[4]; cz = cse[5];
      sr = cse[6]; dr = cse[7];
      cfg = '0; ctl = '0; rs = '0; rb = '0;
      cfg[0 +: W] = mk_cfg(en, halt, fl, SRC_ID, DST_ID);
      ctl[0 +: W] = cz ? 32'hABCD_E000 : 32'hABCD_E001;
      // R3: alternate which request input carries each line
      if (cse[0] ^ cse[1]) begin rs[SRC_ID] = sr; rb[DST_ID] = dr; end
      else                 begin rb[SRC_ID] = sr; rs[DST_ID] = dr; end
      expv = en && !halt && !cz && fl < 4 &&
             (fl == 0 || (fl == 1 && dr) || (fl == 2 && sr) || (fl == 3 && sr && dr));
      step(1);
      chk($sformatf("R1/R2/R3/R4/R7 sweep case %0d valid", cse), 32'(gv), 32'(expv));
      chk($sformatf("R1/R2/R3/R4/R7 sweep case %0d grant", cse), 32'(g), expv ? 32'h1 : 32'h0);
    end
    step(1);
    // R7: only channel 0 ever saw an unsupported type while live
    chk("R7 sticky err", 32'(err), 32'h1);

    // R5/R8: priority sweep with alternating back-pressure
    rs = '0; rb = '0;
    for (int m = 1; m < 16; m++) begin
      for (int b = 0; b < 2; b++) begin
        int low;
        low = 0;
        for (int c = NCH - 1; c >= 0; c--) if (m[c]) low = c;
        cfg = '0; ctl = '0;
        for (int c = 0; c < NCH; c++) begin
          cfg[c*W +: W] = mk_cfg(m[c], 1'b0, 0, 0, 0);
          ctl[c*W +: W] = 32'd5;
        end
        busy = b[0];
        step(1);
        chk($sformatf("R8 busy=%0d mask=%0h valid", b, m), 32'(gv), b ? 0 : 1);
        chk($sformatf("R5 mask=%0h grant", m), 32'(g), b ? 0 : (32'h1 << low));
        if (!b) chk($sformatf("R5 mask=%0h idx", m), 32'(gi), 32'(low));
      end
    end
    busy = 1'b0;

    // R6: global enable clear blocks everything
    ctrl_cfg = 32'h0;
    step(1);
    chk("R6 global off valid", 32'(gv), 0);
    ctrl_cfg = 32'hFFFF_FFFE;
    step(1);
    chk("R6 only bit 0 counts", 32'(gv), 0);
    ctrl_cfg = 32'h1;

    // R7: unsupported channel 0 yields to channel 2
    cfg = '0; ctl = '0;
    cfg[0*W +: W] = mk_cfg(1'b1, 1'b0, 5, 0, 0);
    cfg[2*W +: W] = mk_cfg(1'b1, 1'b0, 0, 0, 0);
    ctl[0*W +: W] = 32'd1; ctl[2*W +: W] = 32'd1;
    step(1);
    chk("R7 skip bad ch0 grant", 32'(g), 32'h4);
    chk("R7 skip bad ch0 idx", 32'(gi), 2);

    // R5: winner persists while eligible, then next takes over
    cfg[1*W +: W] = mk_cfg(1'b1, 1'b0, 0, 0, 0);
    ctl[1*W +: W] = 32'd3;
    step(1);
    chk("R5 ch1 wins", 32'(gi), 1);
    step(3);
    chk("R5 ch1 persists", 32'(gi), 1);
    ctl[1*W +: W] = 32'd0;
    step(1);
    chk("R4 ch1 exhausted", 32'(gi), 2);

    // R9: reset clears sticky flags
    rst_n = 1'b0;
    step(1);
    chk("R9 err cleared", 32'(err), 0);
    chk("R9 valid in reset", 32'(gv), 0);
    rst_n = 1'b1;
    step(1);
    finish_run();
  end
endmodule